// File: doc/BRIEF.md
# Four-Level Interrupt Priority Arbiter

This block decides which pending interrupt request a processor core takes next. It collects requests from six fixed top-level sources, two active-low external request lines and a parameterised set of peripheral sources. It compares each request against the core's two-bit current priority mask and reports the winner. The outputs are a pending flag, the source index, a vector address (two words per source) and the mask value the core loads when it takes that interrupt.

A single read/write configuration register gives each maskable source a two-bit level field. For each external line the register also holds an enable bit and a trigger-mode bit. The register is cleared by the asynchronous reset and by a synchronous clear request from the core's reset instruction. Edge-triggered external requests are captured inside the block and released when the core acknowledges that source.

Source order, which is also the tie-break order (lowest index first): 0 software reset request, 1 stack error, 2 trace, 3 software interrupt, 4 illegal opcode, 5 NMI, 6 external line A, 7 external line B, 8 and up the peripherals.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Sources 0 to 5 are always at level 3. A request from any of them is pending whatever the mask is, including mask 3.
- R2: A maskable request at level L is eligible only when L is not below cur_mask. With cur_mask 3, no maskable request is ever pending.
- R3: Among eligible requests, the one with the highest level wins.
- R4: Among eligible requests with equal levels, the lowest source index wins.
- R5: vec_addr equals twice vec_idx. A stack-error winner therefore gives address 2.
- R6: While a request is pending, new_mask equals the winner's level. A fixed source, including the software interrupt, gives 3.
- R7: Configuration layout, with k = 0 for line A, k = 1 for line B and k = 2 + p for peripheral p. Bits [2k+1:2k] hold the level field of maskable source k. Bit 10 enables line A and bit 11 selects edge mode for line A. Bits 12 and 13 do the same for line B. cfg_we writes the register on a clock edge, and cfg_rdata reads it back. soft_clr clears it and takes priority over a write.
- R8: A disabled external line never produces a request, even when it is driven low.
- R9: An external line in level mode (mode bit 0) requests while it is low. Nothing is stored: the request ends as soon as the line goes high.
- R10: An external line in edge mode (mode bit 1) is captured on the first clock edge that sees it low after it was high. The request stays after the line returns high. It clears only when irq_ack is given while that line is the winner, and an acknowledge of another source leaves it set.
- R11: A level field value of 3 acts as level 2.
- R12: With nothing pending, irq_pend is 0, vec_idx is 0 and new_mask equals cur_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Clears the configuration register (reset instruction) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 14 | Configuration write data |
| cfg_rdata | output | 14 | Configuration read data |
| cur_mask | input | 2 | Current processor priority mask |
| fixed_req | input | 6 | Level-3 source requests, index 0 to 5 |
| ext_n | input | 2 | Active-low external lines, bit 0 = A, bit 1 = B |
| per_req | input | 3 | Peripheral requests |
| irq_ack | input | 1 | Core takes the current winner |
| irq_pend | output | 1 | An eligible request exists |
| vec_idx | output | 4 | Winning source index |
| vec_addr | output | 8 | Winning vector address |
| new_mask | output | 2 | Mask value to load on taking the winner |

## Verification
The arbitration function is driven with several input patterns. One has all peripherals at one level and a request gated at mask 3. Others use a spread of levels, a tie of two peripherals, and two fixed sources at once. These tell strict masking apart from a priority comparison, highest-level selection apart from lowest-index selection, and the clamped field value 3 apart from a true level. The external lines are tried in three ways: disabled, held low in level mode, and pulsed low in edge mode. The pulse separates capture-and-hold from follow-the-input. Acknowledges of a different winner and of the captured line show that only a matching acknowledge releases the capture.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_FIXED = 6;
  localparam int NUM_EXT   = 2;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_TOP = 2'd3;

  // A programmed field of 3 is treated as the highest maskable level.
  function automatic lvl_t clamp_lvl(input lvl_t fld);
    return (fld == 2'd3) ? 2'd2 : fld;
  endfunction
endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
  parameter int CFG_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);
  logic [CFG_W-1:0] cfg_d, cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (soft_clr)  cfg_d = '0;
    else if (we)   cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign q = cfg_q;

  // R7: a clear request wins over a simultaneous write
  p_soft_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (q == '0));
endmodule

// File: rtl/irq_ext_line.sv
module irq_ext_line (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  input  logic en,
  input  logic edge_mode,
  input  logic ack_clr,
  output logic req
);
  logic prev_q, latch_q, latch_d, fall;

  assign fall = prev_q & ~line_n;

  always_comb begin
    latch_d = latch_q;
    if (en && edge_mode && fall)          latch_d = 1'b1;
    else if (!en || !edge_mode || ack_clr) latch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= line_n;
      latch_q <= latch_d;
    end
  end

  assign req = en & (edge_mode ? latch_q : ~line_n);

  // R10: a falling edge seen in edge mode is captured
  p_edge_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(line_n) && en && edge_mode) |=> latch_q);

  // R8: a disabled line never requests
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !req);
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int N     = 11,
  parameter int IDX_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       req,
  input  logic [N-1:0][1:0]  lvl,
  input  lvl_t               cur_mask,
  output logic               pend,
  output logic [IDX_W-1:0]   idx,
  output lvl_t               win_lvl
);
  logic [N-1:0] elig;

  for (genvar g = 0; g < N; g++) begin : g_elig
    assign elig[g] = req[g] && ((lvl[g] == LVL_TOP) || (lvl[g] >= cur_mask));
  end

  always_comb begin
    pend    = 1'b0;
    idx     = '0;
    win_lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!pend || (lvl[i] > win_lvl))) begin
        pend    = 1'b1;
        idx     = IDX_W'(i);
        win_lvl = lvl[i];
      end
    end
  end

  // R2: a granted request is never below the mask
  p_grant_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> ((win_lvl == LVL_TOP) || (win_lvl >= cur_mask)));

  // R3: the winner is requesting
  p_winner_requests_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> req[idx]);
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_PER = 3,
  parameter int VADDR_W = 8
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      soft_clr,
  input  logic                                      cfg_we,
  input  logic [2*(NUM_EXT+NUM_PER)+2*NUM_EXT-1:0] cfg_wdata,
  output logic [2*(NUM_EXT+NUM_PER)+2*NUM_EXT-1:0] cfg_rdata,
  input  logic [1:0]                                cur_mask,
  input  logic [NUM_FIXED-1:0]                      fixed_req,
  input  logic [NUM_EXT-1:0]                        ext_n,
  input  logic [NUM_PER-1:0]                        per_req,
  input  logic                                      irq_ack,
  output logic                                      irq_pend,
  output logic [$clog2(NUM_FIXED+NUM_EXT+NUM_PER)-1:0] vec_idx,
  output logic [VADDR_W-1:0]                        vec_addr,
  output logic [1:0]                                new_mask
);
  localparam int NUM_MASK = NUM_EXT + NUM_PER;
  localparam int NUM_SRC  = NUM_FIXED + NUM_MASK;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int CFG_W    = 2*NUM_MASK + 2*NUM_EXT;
  localparam int CTL_BASE = 2*NUM_MASK;
  localparam int EXT_BASE = NUM_FIXED;
  localparam int PER_BASE = NUM_FIXED + NUM_EXT;

  logic [CFG_W-1:0]          cfg_q;
  logic [NUM_SRC-1:0]        src_req;
  logic [NUM_SRC-1:0][1:0]   src_lvl;
  lvl_t                      win_lvl;

  irq_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .q        (cfg_q)
  );

  assign cfg_rdata = cfg_q;

  for (genvar f = 0; f < NUM_FIXED; f++) begin : g_fixed
    assign src_req[f] = fixed_req[f];
    assign src_lvl[f] = LVL_TOP;
  end

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    logic ack_hit;
    assign ack_hit = irq_ack && irq_pend && (vec_idx == IDX_W'(EXT_BASE + e));
    irq_ext_line u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_n    (ext_n[e]),
      .en        (cfg_q[CTL_BASE + 2*e]),
      .edge_mode (cfg_q[CTL_BASE + 2*e + 1]),
      .ack_clr   (ack_hit),
      .req       (src_req[EXT_BASE + e])
    );
    assign src_lvl[EXT_BASE + e] = clamp_lvl(cfg_q[2*e +: 2]);
  end

  for (genvar p = 0; p < NUM_PER; p++) begin : g_per
    assign src_req[PER_BASE + p] = per_req[p];
    assign src_lvl[PER_BASE + p] = clamp_lvl(cfg_q[2*(NUM_EXT + p) +: 2]);
  end

  irq_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (src_req),
    .lvl      (src_lvl),
    .cur_mask (cur_mask),
    .pend     (irq_pend),
    .idx      (vec_idx),
    .win_lvl  (win_lvl)
  );

  assign vec_addr = VADDR_W'({vec_idx, 1'b0});
  assign new_mask = irq_pend ? win_lvl : cur_mask;

  // R1: any fixed request is taken at level 3
  p_fixed_always_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|fixed_req) |-> (irq_pend && (new_mask == LVL_TOP)));

  // R12: idle arbiter leaves the mask alone
  p_idle_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pend |-> ((new_mask == cur_mask) && (vec_idx == '0)));

  // R5: vector slots are two words apart
  p_vec_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_addr[0] == 1'b0));
endmodule

// File: tb/tb_irq_prio_arbiter.sv
module tb_irq_prio_arbiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_clr;
  logic        cfg_we;
  logic [13:0] cfg_wdata;
  logic [13:0] cfg_rdata;
  logic [1:0]  cur_mask;
  logic [5:0]  fixed_req;
  logic [1:0]  ext_n;
  logic [2:0]  per_req;
  logic        irq_ack;
  logic        irq_pend;
  logic [3:0]  vec_idx;
  logic [7:0]  vec_addr;
  logic [1:0]  new_mask;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  irq_prio_arbiter dut (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cur_mask(cur_mask),
    .fixed_req(fixed_req), .ext_n(ext_n), .per_req(per_req),
    .irq_ack(irq_ack), .irq_pend(irq_pend), .vec_idx(vec_idx),
    .vec_addr(vec_addr), .new_mask(new_mask)
  );

  typedef struct packed {
    logic [13:0] cfg;
    logic [1:0]  mask;
    logic [5:0]  fix;
    logic [2:0]  per;
    logic [1:0]  extn;
    logic        pend;
    logic [3:0]  idx;
    logic [1:0]  nm;
  } vec_t;

  localparam int NV = 12;
  localparam logic [33:0] TBL [NV] = '{
    {14'h000, 2'd0, 6'b000000, 3'b000, 2'b11, 1'b0, 4'd0,  2'd0}, // R12 idle
    {14'h000, 2'd3, 6'b000010, 3'b111, 2'b11, 1'b1, 4'd1,  2'd3}, // R1 R5 stack error
    {14'h2A0, 2'd3, 6'b000000, 3'b111, 2'b11, 1'b0, 4'd0,  2'd3}, // R2 mask 3
    {14'h2A0, 2'd2, 6'b000000, 3'b110, 2'b11, 1'b1, 4'd9,  2'd2}, // R4 tie
    {14'h240, 2'd1, 6'b000000, 3'b111, 2'b11, 1'b1, 4'd10, 2'd2}, // R3 highest
    {14'h240, 2'd2, 6'b000000, 3'b011, 2'b11, 1'b0, 4'd0,  2'd2}, // R2 below mask
    {14'h240, 2'd1, 6'b000000, 3'b011, 2'b11, 1'b1, 4'd9,  2'd1}, // R2 R6 at mask
    {14'h000, 2'd0, 6'b101000, 3'b111, 2'b11, 1'b1, 4'd3,  2'd3}, // R4 R6 swi vs nmi
    {14'h030, 2'd2, 6'b000000, 3'b001, 2'b11, 1'b1, 4'd8,  2'd2}, // R11 field 3
    {14'h401, 2'd1, 6'b000000, 3'b000, 2'b10, 1'b1, 4'd6,  2'd1}, // R9 level mode
    {14'h001, 2'd0, 6'b000000, 3'b000, 2'b10, 1'b0, 4'd0,  2'd0}, // R8 disabled
    {14'h140A,2'd0, 6'b000000, 3'b000, 2'b00, 1'b1, 4'd6,  2'd2}  // R4 ext tie
  };

  vec_t v;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [13:0] val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; soft_clr = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    cur_mask = 2'd2; fixed_req = '0; ext_n = 2'b11; per_req = '0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R7 reset cfg", 32'(cfg_rdata), 32'h0);
    chk("R12 reset pend", 32'(irq_pend), 32'h0);
    chk("R12 reset mask", 32'(new_mask), 32'h2);

    for (int i = 0; i < NV; i++) begin
      v = vec_t'(TBL[i]);
      write_cfg(v.cfg);
      cur_mask = v.mask; fixed_req = v.fix; per_req = v.per; ext_n = v.extn;
      #1;
      chk($sformatf("R2/R3 row%0d pend", i), 32'(irq_pend), 32'(v.pend));
      chk($sformatf("R4 row%0d idx", i), 32'(vec_idx), 32'(v.idx));
      chk($sformatf("R5 row%0d addr", i), 32'(vec_addr), 32'(v.idx) * 2);
      chk($sformatf("R6 row%0d mask", i), 32'(new_mask), 32'(v.nm));
    end
    fixed_req = '0; per_req = '0; ext_n = 2'b11; cur_mask = 2'd0;

    // R7 readback and clears
    write_cfg(14'h2A5);
    chk("R7 readback", 32'(cfg_rdata), 32'h2A5);
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
    chk("R7 soft clear", 32'(cfg_rdata), 32'h0);
    @(negedge clk);
    soft_clr = 1'b1; cfg_we = 1'b1; cfg_wdata = 14'h3FF;
    @(negedge clk);
    soft_clr = 1'b0; cfg_we = 1'b0;
    chk("R7 clear beats write", 32'(cfg_rdata), 32'h0);

    // R10 edge capture on line A, level 1, enabled, edge mode
    write_cfg(14'h0C01);
    ext_n = 2'b10;
    #1;
    chk("R10 before edge", 32'(irq_pend), 32'h0);
    @(negedge clk);
    #1;
    chk("R10 captured idx", 32'(vec_idx), 32'h6);
    chk("R10 captured pend", 32'(irq_pend), 32'h1);
    @(negedge clk);
    ext_n = 2'b11;
    @(negedge clk);
    #1;
    chk("R10 held after release", 32'(irq_pend), 32'h1);
    @(negedge clk);
    fixed_req = 6'b000100; irq_ack = 1'b1;
    #1;
    chk("R1 trace wins", 32'(vec_idx), 32'h2);
    @(negedge clk);
    fixed_req = '0; irq_ack = 1'b0;
    #1;
    chk("R10 other ack keeps", 32'(vec_idx), 32'h6);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    #1;
    chk("R10 own ack clears", 32'(irq_pend), 32'h0);
    chk("R12 idle mask", 32'(new_mask), 32'h0);

    // R9 level mode drops as soon as the line rises
    write_cfg(14'h0401);
    ext_n = 2'b10;
    #1;
    chk("R9 follows low", 32'(irq_pend), 32'h1);
    @(negedge clk);
    ext_n = 2'b11;
    #1;
    chk("R9 follows high", 32'(irq_pend), 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule